// File: doc/BRIEF.md
# Wavetable DMA address and control engine

This block moves sample bytes between a host DMA channel and the synthesizer's local sample memory. Software programs three registers: a control register, a start-address register that counts in 16-byte units, and an extension register whose low nibble supplies the byte offset inside that unit. When a transfer is launched, the block computes the local byte address. On a 16-bit channel it folds that address into the word-interleaved layout. It then streams bytes in the direction chosen by the control register. In the host-to-local direction it can invert the sign bit of each sample.

When a transfer is launched, the start address moves forward by the transfer count in 16-byte units, and the extension nibble takes the low four bits of the count added to its old value. A transfer marked as terminal count drops the DMA request bit at its end. If the interrupt enable bit is set, the transfer also latches a pending terminal-count flag, which drives the interrupt line until software reads the control register.

The system side is a byte stream. The block accepts a byte only on a cycle where `s_valid` and `s_ready` are both high. It presents a byte to the system on `m_valid`, and that byte moves only when `m_ready` is high. While `m_ready` is low, `m_data` and `mem_addr` hold. `s_ready` goes high only during a host-to-local transfer that still has bytes left, and `m_valid` goes high only during a local-to-host transfer that still has bytes left. Local memory is written combinationally on `mem_we` and read combinationally through `mem_rdata` at `mem_addr`.

Top module: `wt_dma_engine`

## Requirements
- R1: On an 8-bit channel (`chan_num` below 4), the first byte of a transfer goes to local address start*16 + ext[3:0], and each further byte goes to the next address up.
- R2: On a 16-bit channel (`chan_num` 4 or higher), the first address is (A & 0xC0000) + 2*(A & 0x1FFF0), where A is the R1 address. Each unit of the count is two bytes, low byte first.
- R3: In the cycle a transfer is launched with count N, start becomes start + (N >> 4) and ext[3:0] becomes (ext[3:0] + N) & 0xF. A count of 0 moves no data and still completes.
- R4: A write to the start register (`reg_sel`=1) clears ext[7:4]. The extension register (`reg_sel`=2) and the control register (`reg_sel`=0) are written and read as full bytes.
- R5: Control bit 1, sampled at launch, sets the direction: 0 means system to local (writes on `mem_wdata`), 1 means local to system (`m_data` = `mem_rdata` with no inversion).
- R6: With control bit 7 set in the system-to-local direction, bit 7 of every byte on a 16-bit channel is inverted, and bit 7 of every byte on an 8-bit channel is inverted unless bit 6 is set.
- R7: With control bit 6 set, the first (low) byte of each unit is written without inversion.
- R8: `dreq` follows control bit 0. A transfer launched with `xfer_tc`=1 clears that bit when its last byte moves. A transfer launched with `xfer_tc`=0 leaves it unchanged.
- R9: At the end of a terminal-count transfer with control bit 5 set, the pending flag is set, and `irq` stays high while the flag is set.
- R10: A control read (`reg_rd` with `reg_sel`=0) returns the stored value with bit 2 set when the channel is 16-bit and bit 6 set when the flag is pending. After the read, the flag is cleared and stored bits 2 and 6 are cleared.
- R11: Data moves only on a valid-and-ready cycle. A `xfer_go` while `xfer_busy` is high is ignored and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_num | input | 3 | Host DMA channel number |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on control) |
| reg_sel | input | 2 | 0 control, 1 start, 2 extension |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_sel` |
| xfer_go | input | 1 | Launch a transfer |
| xfer_len | input | 16 | Transfer count in units |
| xfer_tc | input | 1 | Transfer ends at terminal count |
| xfer_busy | output | 1 | Transfer in progress |
| s_valid | input | 1 | System byte valid |
| s_ready | output | 1 | Block accepts a system byte |
| s_data | input | 8 | System byte |
| m_valid | output | 1 | Byte for the system valid |
| m_ready | input | 1 | System accepts the byte |
| m_data | output | 8 | Byte for the system |
| mem_addr | output | 20 | Local memory byte address |
| mem_we | output | 1 | Local memory write enable |
| mem_wdata | output | 8 | Local memory write data |
| mem_rdata | input | 8 | Local memory read data |
| dreq | output | 1 | DMA request |
| irq | output | 1 | Terminal-count interrupt |

## Verification
On every cycle, the assertions check the following: the address steps by one after each moved byte; a stalled output byte keeps its valid and its address; the idle block writes nothing; the two stream directions never open together; an interrupt rises only from a terminal-count completion with the enable set; a control read leaves the interrupt low; the request bit drops only on a terminal count or a control write; and a start write clears the upper extension nibble. Only the directed scenarios can show the rest. These are the exact base addresses, including the 16-bit fold with the top bits set, the start and extension advance, the inversion pattern of each byte under the bit 6 and bit 7 combinations, the values the control register reads back, and that a second launch during a transfer is ignored.

// File: rtl/wtd_pkg.sv
package wtd_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_EXT   = 2'd2,
    SEL_NONE  = 2'd3
  } wtd_sel_e;
endpackage

// File: rtl/wtd_regs.sv
module wtd_regs
  import wtd_pkg::*;
#(
  parameter int SW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_sel,
  input  logic [SW-1:0] reg_wdata,
  input  logic          chan16,
  input  logic          launch,
  input  logic [LW-1:0] launch_len,
  input  logic          done,
  input  logic          done_tc,
  output logic [7:0]    ctrl_q,
  output logic [SW-1:0] start_q,
  output logic [7:0]    ext_q,
  output logic [SW-1:0] reg_rdata,
  output logic          irq
);
  wtd_sel_e sel;
  logic     pend_q;
  logic     ctrl_rd_hit;
  logic [7:0] ctrl_view;

  assign sel         = wtd_sel_e'(reg_sel);
  assign ctrl_rd_hit = reg_rd && (sel == SEL_CTRL);
  assign ctrl_view   = ctrl_q | {1'b0, pend_q, 3'b000, chan16, 2'b00};
  assign irq         = pend_q;

  always_comb begin
    case (sel)
      SEL_CTRL:  reg_rdata = SW'(ctrl_view);
      SEL_START: reg_rdata = start_q;
      SEL_EXT:   reg_rdata = SW'(ext_q);
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= '0;
      ext_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (launch) begin
        start_q    <= start_q + SW'(launch_len >> 4);
        ext_q[3:0] <= ext_q[3:0] + launch_len[3:0];
      end
      if (ctrl_rd_hit) begin
        ctrl_q <= ctrl_q & 8'hBB;
        pend_q <= 1'b0;
      end
      if (done && done_tc) begin
        ctrl_q[0] <= 1'b0;
        if (ctrl_q[5]) pend_q <= 1'b1;
      end
      if (reg_wr) begin
        case (sel)
          SEL_CTRL:  ctrl_q <= reg_wdata[7:0];
          SEL_START: begin
            start_q    <= reg_wdata;
            ext_q[7:4] <= 4'h0;
          end
          SEL_EXT:   ext_q <= reg_wdata[7:0];
          default:   ;
        endcase
      end
    end
  end

  // R9: interrupt only rises from an enabled terminal-count completion
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done && done_tc && ctrl_q[5]));

  // R10: a control read leaves the interrupt low
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd_hit && !(done && done_tc && ctrl_q[5])) |=> !irq);

  // R8: request bit drops only on terminal count or a control write
  a_r8_dreq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[0]) |-> ($past(done && done_tc) || $past(reg_wr && sel == SEL_CTRL)));

  // R4: a start write clears the upper extension nibble
  a_r4_ext_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_START) |=> (ext_q[7:4] == 4'h0));
endmodule

// File: rtl/wtd_addr.sv
module wtd_addr #(
  parameter int SW = 16,
  localparam int AW = SW + 4
) (
  input  logic [SW-1:0] start,
  input  logic [3:0]    ext_lo,
  input  logic          chan16,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] raw;
  logic [AW-1:0] fold_hi;
  logic [AW-1:0] fold_lo;

  assign raw     = {start, ext_lo};
  assign fold_hi = {raw[AW-1:AW-2], {(AW-2){1'b0}}};
  assign fold_lo = AW'({raw[AW-4:4], 5'b00000});
  assign addr    = chan16 ? (fold_hi + fold_lo) : raw;

  // R2: a folded 16-bit address always lands on a 32-byte boundary
  always_comb begin
    if (chan16 === 1'b1) begin
      a_r2_fold_align: assert (addr[4:0] == 5'b00000);
    end
  end
endmodule

// File: rtl/wtd_mover.sv
module wtd_mover #(
  parameter int AW = 20,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [LW-1:0] len,
  input  logic          tc,
  input  logic          dir_in,
  input  logic          inv_in,
  input  logic          lraw_in,
  input  logic          chan16,
  input  logic [AW-1:0] base,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          m_ready,
  input  logic [7:0]    mem_rdata,
  output logic          launch,
  output logic          busy,
  output logic          s_ready,
  output logic          m_valid,
  output logic [7:0]    m_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          done,
  output logic          done_tc
);
  logic          busy_q, dir_q, inv_q, lraw_q, w16_q, tc_q, hi_q;
  logic [AW-1:0] cur_q;
  logic [LW:0]   left_q;
  logic          has, fire, flip;

  assign launch    = go && !busy_q;
  assign busy      = busy_q;
  assign has       = (left_q != '0);
  assign s_ready   = busy_q && !dir_q && has;
  assign m_valid   = busy_q && dir_q && has;
  assign fire      = (s_ready && s_valid) || (m_valid && m_ready);
  assign done      = busy_q && (!has || (fire && left_q == (LW+1)'(1)));
  assign done_tc   = tc_q;
  assign flip      = inv_q && (hi_q || !lraw_q);
  assign mem_addr  = cur_q;
  assign mem_we    = s_ready && s_valid;
  assign mem_wdata = s_data ^ {flip, 7'b0000000};
  assign m_data    = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; dir_q <= 1'b0; inv_q <= 1'b0; lraw_q <= 1'b0;
      w16_q  <= 1'b0; tc_q  <= 1'b0; hi_q  <= 1'b0;
      cur_q  <= '0;   left_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      dir_q  <= dir_in;
      inv_q  <= inv_in;
      lraw_q <= lraw_in;
      w16_q  <= chan16;
      tc_q   <= tc;
      hi_q   <= 1'b0;
      cur_q  <= base;
      left_q <= chan16 ? {len, 1'b0} : {1'b0, len};
    end else if (busy_q) begin
      if (fire) begin
        cur_q  <= cur_q + AW'(1);
        left_q <= left_q - (LW+1)'(1);
        hi_q   <= w16_q && !hi_q;
      end
      if (done) busy_q <= 1'b0;
    end
  end

  // R1: each moved byte steps the local address by one
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!busy_q || mem_addr == $past(mem_addr) + AW'(1)));

  // R11: a stalled output byte keeps valid and address
  a_r11_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(mem_addr)));

  // R11: nothing is written while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mem_we);

  // R5: only one stream direction is open at a time
  a_r5_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !m_valid);
endmodule

// File: rtl/wt_dma_engine.sv
module wt_dma_engine #(
  parameter int SW         = 16,
  parameter int LW         = 16,
  parameter int CHW        = 3,
  parameter int WIDE_FIRST = 4,
  localparam int AW = SW + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CHW-1:0] chan_num,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [1:0]     reg_sel,
  input  logic [SW-1:0]  reg_wdata,
  output logic [SW-1:0]  reg_rdata,
  input  logic           xfer_go,
  input  logic [LW-1:0]  xfer_len,
  input  logic           xfer_tc,
  output logic           xfer_busy,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [7:0]     s_data,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [7:0]     m_data,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [7:0]     mem_wdata,
  input  logic [7:0]     mem_rdata,
  output logic           dreq,
  output logic           irq
);
  logic          chan16;
  logic [7:0]    ctrl_q, ext_q;
  logic [SW-1:0] start_q;
  logic [AW-1:0] base;
  logic          launch, done, done_tc;

  assign chan16 = (32'(chan_num) >= WIDE_FIRST);
  assign dreq   = ctrl_q[0];

  wtd_regs #(.SW(SW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .chan16(chan16),
    .launch(launch), .launch_len(xfer_len), .done(done), .done_tc(done_tc),
    .ctrl_q(ctrl_q), .start_q(start_q), .ext_q(ext_q),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  wtd_addr #(.SW(SW)) u_addr (
    .start(start_q), .ext_lo(ext_q[3:0]), .chan16(chan16), .addr(base)
  );

  wtd_mover #(.AW(AW), .LW(LW)) u_mover (
    .clk(clk), .rst_n(rst_n), .go(xfer_go), .len(xfer_len), .tc(xfer_tc),
    .dir_in(ctrl_q[1]), .inv_in(ctrl_q[7]), .lraw_in(ctrl_q[6]),
    .chan16(chan16), .base(base), .s_valid(s_valid), .s_data(s_data),
    .m_ready(m_ready), .mem_rdata(mem_rdata), .launch(launch),
    .busy(xfer_busy), .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .done(done), .done_tc(done_tc)
  );
endmodule

// File: tb/sim_wt_dma_engine.sv
`timescale 1ns/1ps
module sim_wt_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  chan_num = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        xfer_go = 0, xfer_tc = 0, xfer_busy;
  logic [15:0] xfer_len = '0;
  logic        s_valid = 0, s_ready;
  logic [7:0]  s_data = '0;
  logic        m_valid, m_ready = 0;
  logic [7:0]  m_data;
  logic [19:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        dreq, irq;

  int checks = 0, fails = 0, wcount = 0;
  bit finished = 0;
  logic [7:0] lmem [int unsigned];

  always #2 clk = ~clk;

  wt_dma_engine u0 (.*);

  function automatic logic [7:0] pat(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h3C;
  endfunction
  assign mem_rdata = pat(mem_addr);

  always @(posedge clk) if (mem_we) begin
    lmem[int'(mem_addr)] = mem_wdata;
    wcount++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] s, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic peek(logic [1:0] s, output logic [15:0] v);
    reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic ctrl_read(output logic [15:0] v);
    @(negedge clk); reg_sel = 0; reg_rd = 1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic launch(logic [15:0] n, logic tc);
    @(negedge clk); xfer_go = 1; xfer_len = n; xfer_tc = tc;
    @(negedge clk); xfer_go = 0;
  endtask

  function automatic logic [7:0] dat(int k);
    return 8'(k * 37 + 11);
  endfunction

  // push nb bytes; gap cycles after byte 'gap_at'; stray go at byte 1
  task automatic push(string req, int nb, int gap_at, bit stray);
    for (int i = 0; i < nb; i++) begin
      s_valid = 1; s_data = dat(i);
      if (stray && i == 1) begin xfer_go = 1; xfer_len = 16'h0100; end
      #1 chk({req, " s_ready"}, s_ready, 1);
      @(negedge clk); xfer_go = 0;
      if (i == gap_at) begin
        int wc;
        s_valid = 0; wc = wcount;
        repeat (3) @(negedge clk);
        chk("R11 no write in gap", wcount, wc);
        chk("R11 busy in gap", xfer_busy, 1);
      end
    end
    s_valid = 0;
    #1 chk({req, " done"}, xfer_busy, 0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(0, v); chk("R10 reset ctrl", v, 0);
    peek(1, v); chk("R3 reset start", v, 0);
    chk("R8 reset dreq", dreq, 0);
    chk("R9 reset irq", irq, 0);
  endtask

  task automatic t_byte_in();
    logic [15:0] v; int w0;
    chan_num = 3;
    wreg(2, 16'h00A5); wreg(1, 16'h0123);
    peek(2, v); chk("R4 ext hi cleared", v, 16'h0005);
    wreg(0, 16'h0001);
    #1 chk("R8 dreq set", dreq, 1);
    w0 = wcount;
    launch(16'd20, 1);
    push("R11", 20, 4, 1);
    chk("R11 write count", wcount - w0, 20);
    for (int k = 0; k < 20; k++)
      chk("R1 byte addr/data", lmem.exists(32'h1235 + k) ? lmem[32'h1235 + k] : 8'hxx, dat(k));
    peek(1, v); chk("R3 start advance", v, 16'h0124);
    peek(2, v); chk("R3 ext advance", v, 16'h0009);
    chk("R8 dreq cleared", dreq, 0);
    chk("R9 no irq without enable", irq, 0);
  endtask

  task automatic t_word_in_inv();
    logic [15:0] v;
    chan_num = 4;
    wreg(2, 16'h0003); wreg(1, 16'h1234);
    wreg(0, 16'h00A1);
    launch(16'd3, 1);
    push("R6", 6, -1, 0);
    for (int k = 0; k < 6; k++)
      chk("R2 R6 word data", lmem.exists(32'h24680 + k) ? lmem[32'h24680 + k] : 8'hxx, dat(k) ^ 8'h80);
    peek(1, v); chk("R3 start small count", v, 16'h1234);
    peek(2, v); chk("R3 ext small count", v, 16'h0006);
    chk("R9 irq raised", irq, 1);
    ctrl_read(v); chk("R10 read with pending", v, 16'h00E4);
    #1 chk("R10 irq cleared", irq, 0);
    ctrl_read(v); chk("R10 read after clear", v, 16'h00A4);
  endtask

  task automatic t_word_lowraw();
    chan_num = 7;
    wreg(2, 16'h0000); wreg(1, 16'hD000);
    wreg(0, 16'h00C1);
    launch(16'd2, 1);
    push("R7", 4, -1, 0);
    for (int k = 0; k < 4; k++)
      chk("R2 R7 fold and low raw", lmem.exists(32'hE0000 + k) ? lmem[32'hE0000 + k] : 8'hxx,
          (k % 2 == 1) ? (dat(k) ^ 8'h80) : dat(k));
    chk("R9 no irq bit5 clear", irq, 0);
    chk("R8 dreq cleared word", dreq, 0);
  endtask

  task automatic t_byte_out();
    logic [15:0] v; logic [7:0] held; int w0;
    chan_num = 2;
    wreg(2, 16'h0002); wreg(1, 16'h0040);
    wreg(0, 16'h0083);
    w0 = wcount;
    launch(16'd5, 0);
    for (int k = 0; k < 5; k++) begin
      m_ready = (k != 2);
      #1 chk("R5 m_valid", m_valid, 1);
      chk("R1 out addr", mem_addr, 20'h402 + k);
      chk("R5 out data no inversion", m_data, pat(20'h402 + k));
      if (k == 2) begin
        held = m_data;
        repeat (3) @(negedge clk);
        #1 chk("R11 stall holds", m_data, held);
        m_ready = 1;
      end
      @(negedge clk);
    end
    m_ready = 0;
    #1 chk("R5 out done", xfer_busy, 0);
    chk("R5 no local writes", wcount - w0, 0);
    chk("R8 dreq kept without tc", dreq, 1);
    peek(2, v); chk("R3 ext out", v, 16'h0007);
  endtask

  task automatic t_zero_len();
    logic [15:0] v;
    chan_num = 2;
    wreg(0, 16'h0021);
    launch(16'd0, 1);
    @(negedge clk);
    chk("R3 zero done", xfer_busy, 0);
    chk("R8 zero dreq", dreq, 0);
    chk("R9 zero irq", irq, 1);
    peek(1, v); chk("R3 zero start", v, 16'h0040);
    ctrl_read(v); chk("R10 8-bit pending read", v, 16'h0060);
    chan_num = 0;
    wreg(0, 16'h0044);
    ctrl_read(v); chk("R10 stored bits read", v, 16'h0044);
    peek(0, v); chk("R10 stored bits cleared", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_in();
    t_word_in_inv();
    t_word_lowraw();
    t_byte_out();
    t_zero_len();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule